// File: doc/BRIEF.md
# Freeze-Gated Volume and Mute Register Bank

This block holds the master volume, the per-channel volumes and the channel mute mask of an audio output stage behind a byte-wide register bus. Every gated register exists twice: a shadow copy that the bus writes and reads, and a live copy that drives the parallel outputs into the gain datapath.

A freeze flag sits in a separate configuration register. While the flag is clear, a write reaches the shadow and the live copy at the same clock edge. While it is set, writes collect only in the shadows and the outputs hold still. The bus write that clears the flag copies every shadow to its live copy at one edge. Software can therefore stage a gain change across many registers and release it as one step.

Top module: `vol_freeze_bank`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a clock edge, every live output, every shadow register and the freeze flag become zero.
- R2: The configuration register is at address 0x04. Its bit 2 is the freeze flag (1 = frozen). A read of 0x04 returns the flag in bit 2 and zero in every other bit. Writes to the other bits have no effect.
- R3: Gated addresses are as follows. 0x07 is the master volume high byte (`master_vol_o[15:8]`). 0x08 is the master volume low byte (`master_vol_o[7:0]`). 0x09+k is the volume of channel k (`chan_vol_o[8k+7:8k]`), for k = 0 to 9. 0x13 is the mute mask (`mute_o`).
- R4: While the flag is clear, a write to a gated address updates that register's live output at the same clock edge that updates its shadow.
- R5: While the flag is set, no write changes any live output.
- R6: A read of a gated address returns the shadow value, without delay, from the address presented. This is the value last written, whether or not it has reached the output yet.
- R7: A write to 0x04 with bit 2 at 0 while the flag is set copies every shadow to its live output at that one clock edge. All pending changes appear together.
- R8: A write to 0x04 with bit 2 at 1 while the flag is already set keeps the flag set and commits nothing.
- R9: A write to any address other than 0x04 and 0x07 to 0x13 is ignored, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| master_vol_o | output | 16 | Live master volume |
| chan_vol_o | output | 80 | Live channel volumes, channel k in bits 8k+7:8k |
| mute_o | output | 8 | Live mute mask |

## Verification
The assertions check several properties on every cycle:
- the outputs stay unchanged while the bank is frozen and no commit occurs;
- every live value equals its shadow right after a commit;
- an unfrozen write to the mute mask shows on the next cycle;
- a written address reads back its data;
- reset clears the bank.

Some behaviours only the bench scenarios can show:
- that a commit releases a batch of staged writes spread over master, first and last channel and mute, with every output still old one cycle before the commit and new after it;
- that re-setting the flag does not release anything;
- that unmapped addresses and spare configuration bits leave no trace.

// File: rtl/volfrz_pkg.sv
// Package: shared address map and selector type of the freeze-gated bank.
// Assumes an 8-bit register bus; the channel count is a parameter of the top.
package volfrz_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int CFG_ADDR   = 'h04;
    localparam int FRZ_BIT    = 2;
    localparam int GATED_BASE = 'h07;
    localparam int MASTER_B   = 2;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_CFG   = 2'd1,
        RD_GATED = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/volfrz_decode.sv
// Module: address decoder. Turns a bus address and write strobe into a
// configuration write, a one-hot gated write vector and a read selector.
// Assumes the gated registers occupy NUM_GATED consecutive addresses.
module volfrz_decode
    import volfrz_pkg::*;
#(
    parameter int NUM_GATED = 13
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic                 cfg_we,
    output logic [NUM_GATED-1:0] gated_we,
    output rd_sel_e              rd_sel,
    output logic [ADDR_W-1:0]    rd_idx
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic              is_cfg;

    // Offset from the first gated address and the range test.
    always_comb begin
        offset   = addr - ADDR_W'(GATED_BASE);
        in_range = (addr >= ADDR_W'(GATED_BASE)) && (offset < ADDR_W'(NUM_GATED));
        is_cfg   = (addr == ADDR_W'(CFG_ADDR));
    end

    // One write-enable line per gated register.
    for (genvar i = 0; i < NUM_GATED; i++) begin : g_we
        assign gated_we[i] = we && in_range && (offset == ADDR_W'(i));
    end

    // Configuration write and read-side selection.
    always_comb begin
        cfg_we = we && is_cfg;
        rd_idx = offset;
        if (is_cfg)        rd_sel = RD_CFG;
        else if (in_range) rd_sel = RD_GATED;
        else               rd_sel = RD_NONE;
    end
endmodule

// File: rtl/volfrz_ctrl.sv
// Module: freeze control. Holds the freeze flag and raises a one-cycle
// commit when a configuration write clears a set flag.
// Assumes cfg_we is already qualified by the write strobe.
module volfrz_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic frz_wbit,
    output logic freeze_q,
    output logic commit
);
    // Commit fires only on the set-to-clear transition caused by a write.
    always_comb begin
        commit = freeze_q && cfg_we && !frz_wbit;
    end

    // Freeze flag register, loaded by configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      freeze_q <= 1'b0;
        else if (cfg_we) freeze_q <= frz_wbit;
    end
endmodule

// File: rtl/volfrz_cell.sv
// Module: one double-buffered register. The shadow takes every write; the
// live copy takes the write only when unfrozen, or the shadow on a commit.
// Assumes wr and commit never come in the same cycle (single-port bus), but
// a commit copies the shadow as updated in that cycle in either case.
module volfrz_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         frozen,
    input  logic         commit,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] live_o
);
    logic [W-1:0] shadow_nxt;

    // Next shadow value including a write in this cycle.
    always_comb begin
        shadow_nxt = wr ? wdata : shadow_o;
    end

    // Shadow register: follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_o <= '0;
        else        shadow_o <= shadow_nxt;
    end

    // Live register: direct update when unfrozen, bulk copy on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)              live_o <= '0;
        else if (commit)         live_o <= shadow_nxt;
        else if (wr && !frozen)  live_o <= wdata;
    end
endmodule

// File: rtl/volfrz_rdmux.sv
// Module: read-data multiplexer. Returns the freeze flag for the
// configuration address, a shadow byte for gated addresses, else zero.
// Assumes shadow_flat packs register i at bits i*DATA_W.
module volfrz_rdmux
    import volfrz_pkg::*;
#(
    parameter int NUM_GATED = 13
) (
    input  rd_sel_e                       rd_sel,
    input  logic [ADDR_W-1:0]             rd_idx,
    input  logic                          freeze_q,
    input  logic [NUM_GATED*DATA_W-1:0]   shadow_flat,
    output logic [DATA_W-1:0]             rdata
);
    // Select the byte addressed by the read selector and index.
    always_comb begin
        rdata = '0;
        case (rd_sel)
            RD_CFG:   rdata[FRZ_BIT] = freeze_q;
            RD_GATED: begin
                for (int i = 0; i < NUM_GATED; i++) begin
                    if (rd_idx == ADDR_W'(i)) rdata = shadow_flat[i*DATA_W +: DATA_W];
                end
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/vol_freeze_bank.sv
// Module: top of the freeze-gated volume and mute register bank.
// Register order: master high, master low, channels 0..NUM_CH-1, mute.
// Assumes one bus access per cycle and a synchronous active-low reset.
module vol_freeze_bank
    import volfrz_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic [7:0]               bus_wdata,
    input  logic                     bus_we,
    output logic [7:0]               bus_rdata,
    output logic [15:0]              master_vol_o,
    output logic [NUM_CH*8-1:0]      chan_vol_o,
    output logic [7:0]               mute_o
);
    localparam int NUM_GATED = MASTER_B + NUM_CH + 1;
    localparam int MUTE_IDX  = NUM_GATED - 1;

    logic                          cfg_we;
    logic [NUM_GATED-1:0]          gated_we;
    rd_sel_e                       rd_sel;
    logic [ADDR_W-1:0]             rd_idx;
    logic                          freeze_q;
    logic                          commit;
    logic [NUM_GATED*DATA_W-1:0]   shadow_flat;
    logic [NUM_GATED*DATA_W-1:0]   live_flat;

    volfrz_decode #(.NUM_GATED(NUM_GATED)) u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .cfg_we   (cfg_we),
        .gated_we (gated_we),
        .rd_sel   (rd_sel),
        .rd_idx   (rd_idx)
    );

    volfrz_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .frz_wbit (bus_wdata[FRZ_BIT]),
        .freeze_q (freeze_q),
        .commit   (commit)
    );

    // One double-buffered cell per gated register.
    for (genvar i = 0; i < NUM_GATED; i++) begin : g_cell
        volfrz_cell #(.W(DATA_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (gated_we[i]),
            .wdata    (bus_wdata),
            .frozen   (freeze_q),
            .commit   (commit),
            .shadow_o (shadow_flat[i*DATA_W +: DATA_W]),
            .live_o   (live_flat[i*DATA_W +: DATA_W])
        );
    end

    volfrz_rdmux #(.NUM_GATED(NUM_GATED)) u_rd (
        .rd_sel      (rd_sel),
        .rd_idx      (rd_idx),
        .freeze_q    (freeze_q),
        .shadow_flat (shadow_flat),
        .rdata       (bus_rdata)
    );

    // Master volume: high byte at index 0, low byte at index 1.
    assign master_vol_o = {live_flat[0 +: DATA_W], live_flat[DATA_W +: DATA_W]};

    // Channel volumes follow the master bytes in address order.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        assign chan_vol_o[k*8 +: 8] = live_flat[(MASTER_B+k)*DATA_W +: DATA_W];
    end

    assign mute_o = live_flat[MUTE_IDX*DATA_W +: DATA_W];
endmodule

// File: rtl/vol_freeze_bank_chk.sv
// Module: checker bound to vol_freeze_bank. Observes ports plus the freeze
// flag, the commit pulse and the shadow vector.
// Assumes the register order of the top module.
module vol_freeze_bank_chk #(
    parameter int NUM_CH = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [7:0]                  bus_addr,
    input logic [7:0]                  bus_wdata,
    input logic                        bus_we,
    input logic [7:0]                  bus_rdata,
    input logic [15:0]                 master_vol_o,
    input logic [NUM_CH*8-1:0]         chan_vol_o,
    input logic [7:0]                  mute_o,
    input logic                        freeze_q,
    input logic                        commit,
    input logic [(NUM_CH+3)*8-1:0]     shadow_flat
);
    localparam int NG = NUM_CH + 3;

    logic [NG*8-1:0] obs_live;
    logic            gated_hit;

    // Rebuild the live vector from the output ports.
    always_comb begin
        obs_live = '0;
        obs_live[0 +: 8] = master_vol_o[15:8];
        obs_live[8 +: 8] = master_vol_o[7:0];
        for (int k = 0; k < NUM_CH; k++) obs_live[(2+k)*8 +: 8] = chan_vol_o[k*8 +: 8];
        obs_live[(NG-1)*8 +: 8] = mute_o;
        gated_hit = (bus_addr >= 8'h07) && (bus_addr < 8'(7 + NG));
    end

    // R1: reset clears outputs, shadows and the flag.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (obs_live == '0 && shadow_flat == '0 && !freeze_q));

    // R5: frozen without commit keeps every output unchanged.
    a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !commit) |=> $stable(obs_live));

    // R7: after a commit every live value equals its shadow.
    a_r7_commit_all: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (obs_live == shadow_flat));

    // R4: unfrozen write to the mute mask reaches the output next cycle.
    a_r4_unfrozen_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_q && bus_we && bus_addr == 8'(7 + NG - 1)) |=> (mute_o == $past(bus_wdata)));

    // R6: a gated write reads back at once from the same address.
    a_r6_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && gated_hit) ##1 (bus_addr == $past(bus_addr)) |-> (bus_rdata == $past(bus_wdata)));

    // R8: a write keeping bit 2 set never releases a commit.
    a_r8_no_commit_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h04 && bus_wdata[2]) |-> !commit);
endmodule

bind vol_freeze_bank vol_freeze_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_rdata    (bus_rdata),
    .master_vol_o (master_vol_o),
    .chan_vol_o   (chan_vol_o),
    .mute_o       (mute_o),
    .freeze_q     (freeze_q),
    .commit       (commit),
    .shadow_flat  (shadow_flat)
);

// File: tb/vol_freeze_bank_bench.sv
// Bench: table walk of unfrozen accesses, then directed freeze, commit,
// re-freeze and reset scenarios against a requirement-level model.
module vol_freeze_bank_bench;
    localparam int NCH = 10;
    localparam int NG  = NCH + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic             bus_we = 1'b0;
    logic [7:0]       bus_rdata;
    logic [15:0]      master_vol_o;
    logic [NCH*8-1:0] chan_vol_o;
    logic [7:0]       mute_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_live   [NG];
    logic [7:0] m_shadow [NG];
    logic       m_frz;

    // {check_live, addr, wdata, expected read}
    localparam logic [24:0] VEC [8] = '{
        25'h1_07A5A5, 25'h1_083C3C, 25'h1_091111, 25'h1_129999,
        25'h1_13F0F0, 25'h0_04FB00, 25'h0_147700, 25'h0_065500
    };

    always #4 clk = ~clk;

    vol_freeze_bank #(.NUM_CH(NCH)) u_vol_freeze_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_rdata    (bus_rdata),
        .master_vol_o (master_vol_o),
        .chan_vol_o   (chan_vol_o),
        .mute_o       (mute_o)
    );

    function automatic logic [7:0] live_at(int i);
        if (i == 0) return master_vol_o[15:8];
        if (i == 1) return master_vol_o[7:0];
        if (i == NG - 1) return mute_o;
        return chan_vol_o[(i-2)*8 +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_live(string req);
        for (int i = 0; i < NG; i++) check(req, 32'(live_at(i)), 32'(m_live[i]));
    endtask

    task automatic model_reset();
        for (int i = 0; i < NG; i++) begin
            m_live[i] = '0;
            m_shadow[i] = '0;
        end
        m_frz = 1'b0;
    endtask

    task automatic model_write(logic [7:0] a, logic [7:0] d);
        if (a == 8'h04) begin
            if (m_frz && !d[2]) for (int i = 0; i < NG; i++) m_live[i] = m_shadow[i];
            m_frz = d[2];
        end else if (a >= 8'h07 && a < 8'(7 + NG)) begin
            m_shadow[a-7] = d;
            if (!m_frz) m_live[a-7] = d;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(req, 32'(bus_rdata), 32'(exp));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on outputs and reads.
        check_live("R1 reset outputs");
        rd_chk(8'h13, 8'h00, "R1 reset shadow");
        rd_chk(8'h04, 8'h00, "R1 reset flag");

        // Table walk, unfrozen: R3/R4 live, R2/R9 masked and unmapped, R6 reads.
        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][23:16], VEC[v][15:8]);
            check_live(VEC[v][24] ? "R4 R3 unfrozen write" : "R9 R2 no output effect");
            rd_chk(VEC[v][23:16], VEC[v][7:0], VEC[v][24] ? "R6 readback" : "R9 R2 read");
        end

        // R2: set freeze, flag reads back in bit 2.
        wr(8'h04, 8'h04);
        rd_chk(8'h04, 8'h04, "R2 flag set");

        // R5/R6: staged writes do not move outputs but read back.
        wr(8'h07, 8'h11); check_live("R5 frozen master hi");
        wr(8'h08, 8'h22); check_live("R5 frozen master lo");
        wr(8'h09, 8'h33); check_live("R5 frozen ch0");
        wr(8'h12, 8'h44); check_live("R5 frozen ch9");
        wr(8'h13, 8'h0F); check_live("R5 frozen mute");
        rd_chk(8'h09, 8'h33, "R6 shadow read ch0");
        rd_chk(8'h13, 8'h0F, "R6 shadow read mute");

        // R8: writing the flag set again commits nothing.
        wr(8'h04, 8'hFF); check_live("R8 refreeze holds");
        rd_chk(8'h04, 8'h04, "R8 flag still set");

        // R7: outputs old up to the commit edge, all new right after.
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 8'h00; bus_we = 1'b1;
        #1 check_live("R7 before commit");
        @(negedge clk);
        bus_we = 1'b0;
        model_write(8'h04, 8'h00);
        check(  "R7 master", 32'(master_vol_o), 32'h1122);
        check(  "R7 mute",   32'(mute_o),       32'h0F);
        check_live("R7 all committed");

        // R1: reset while frozen with pending data clears everything.
        wr(8'h04, 8'h04);
        wr(8'h13, 8'hAA);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        check_live("R1 reset after freeze");
        rd_chk(8'h13, 8'h00, "R1 shadow cleared");
        rd_chk(8'h04, 8'h00, "R1 flag cleared");

        // R4 again after reset: direct write is live at once.
        wr(8'h0A, 8'h5A); check_live("R4 write after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule